// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked replacement for an analog retriggerable monostable. Three asynchronous control pins start a pulse: `fall_trig_i` fires on its falling edge, `rise_trig_i` fires on its rising edge, and `clr_n_i` fires on its rising edge. Each trigger counts only when the other two pins sit at their enabling levels. The pulse length is a cycle count taken from `width_i`. That count replaces an external resistor and capacitor. A trigger that arrives during a pulse restarts the count, so the pulse grows longer.

Driving `clr_n_i` low ends any pulse at once and blocks every trigger for as long as it stays low. If a clear cuts a running pulse short, the block waits a recovery interval before it takes another trigger. A short lockout after each accepted trigger stops a second edge that follows too closely from counting as a retrigger. All pins are plain levels; there is no data stream and no handshake.

Top module: `retrig_oneshot`

## Requirements
- R1: Out of reset, and whenever no pulse is running, `q_o` is 0 and `qn_o` is 1. `qn_o` is always the exact complement of `q_o`.
- R2: A falling edge on `fall_trig_i` starts a pulse only if `rise_trig_i` and `clr_n_i` are both 1 when the edge is seen.
- R3: A rising edge on `rise_trig_i` starts a pulse only if `fall_trig_i` is 0 and `clr_n_i` is 1 when the edge is seen.
- R4: A rising edge on `clr_n_i` starts a pulse only if `fall_trig_i` is 0 and `rise_trig_i` is 1 when the edge is seen.
- R5: While `clr_n_i` is 0, `q_o` is driven to 0 within SYNC_STAGES+1 cycles. Every trigger event during that time has no effect on `q_o`.
- R6: An accepted trigger during a pulse restarts the timing. `q_o` stays 1 until a full width after the last accepted trigger.
- R7: `q_o` rises exactly SYNC_STAGES+1 clock edges after a triggering pin change, whatever value `width_i` holds.
- R8: After an accepted trigger, the next LOCK_CYC clock edges accept no trigger. The edge after that accepts triggers again.
- R9: If `clr_n_i` goes low while a pulse is running, triggers stay blocked until REC_CYC edges after `clr_n_i` returns high. This includes the clear's own rising edge. A clear taken from idle adds no recovery time.
- R10: `width_i` is sampled at each accepted trigger. The pulse lasts that many cycles, and a width of 0 gives a 1-cycle pulse. Later changes to `width_i` do not affect a pulse already running.
- R11: A rising edge on `fall_trig_i` and a falling edge on `rise_trig_i` never start a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fall_trig_i | input | 1 | Trigger pin, active on its falling edge |
| rise_trig_i | input | 1 | Trigger pin, active on its rising edge |
| clr_n_i | input | 1 | Active-low clear; its rising edge is also a trigger |
| width_i | input | WIDTH_W | Pulse length in clock cycles, sampled at each trigger |
| q_o | output | 1 | Pulse output, high while a pulse runs |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
Two functions can land on the same cycle: the rising edge of the clear, which counts as a trigger, and the recovery lockout, which that same clear starts when it cuts a pulse short. The bench starts a long pulse and aborts it with a clear. It then releases the clear while `fall_trig_i` is low and `rise_trig_i` is high, so the release edge itself meets the trigger conditions. The result is judged by `q_o` staying low through the whole window. An ordinary trigger issued after the recovery must then give a pulse of full width. A second overlap, a retrigger falling right on the last edge of the lockout, is checked one edge either side of that boundary by measuring the total pulse length.

// File: rtl/retrig_oneshot_pkg.sv
`timescale 1ns/1ps
package retrig_oneshot_pkg;

  // which transition of a synchronised pin is reported as an event
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;

  // pin order used inside the block
  localparam int PIN_FALL = 0;
  localparam int PIN_RISE = 1;
  localparam int PIN_CLR  = 2;
  localparam int NUM_PINS = 3;

endpackage

// File: rtl/ros_edge_sync.sv
`timescale 1ns/1ps
module ros_edge_sync
  import retrig_oneshot_pkg::*;
#(
  parameter int         STAGES  = 2,
  parameter logic       RST_VAL = 1'b0,
  parameter edge_kind_e KIND    = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic evt
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign evt = lvl & ~prev;
    end else begin : g_fall
      assign evt = ~lvl & prev;
    end
  endgenerate

endmodule

// File: rtl/ros_trig_gate.sv
`timescale 1ns/1ps
module ros_trig_gate #(
  parameter int LOCK_CYC = 1,
  parameter int REC_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_lvl,
  input  logic a_evt,
  input  logic b_lvl,
  input  logic b_evt,
  input  logic c_lvl,
  input  logic c_evt,
  input  logic q_act,
  output logic fire,
  output logic lock_busy,
  output logic rec_busy
);

  localparam int LW = $clog2(LOCK_CYC + 2);
  localparam int RW = $clog2(REC_CYC + 2);

  logic [LW-1:0] lock_cnt;
  logic [RW-1:0] rec_cnt;
  logic          cand;

  // qualified trigger sources
  assign cand = (a_evt & b_lvl & c_lvl)
              | (b_evt & ~a_lvl & c_lvl)
              | (c_evt & ~a_lvl & b_lvl);

  assign lock_busy = (lock_cnt != '0);
  assign rec_busy  = (rec_cnt  != '0);
  assign fire      = cand & c_lvl & ~lock_busy & ~rec_busy;

  // retrigger lockout after every accepted trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
    end else if (fire) begin
      lock_cnt <= LW'(LOCK_CYC);
    end else if (lock_busy) begin
      lock_cnt <= lock_cnt - LW'(1);
    end
  end

  // recovery armed when clear cuts a pulse short, held while clear is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_cnt <= '0;
    end else if (!c_lvl) begin
      rec_cnt <= (q_act || rec_busy) ? RW'(REC_CYC) : '0;
    end else if (rec_busy) begin
      rec_cnt <= rec_cnt - RW'(1);
    end
  end

endmodule

// File: rtl/ros_pulse_timer.sv
`timescale 1ns/1ps
module ros_pulse_timer #(
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               clr_lvl,
  input  logic [WIDTH_W-1:0] width,
  output logic               q
);

  logic [WIDTH_W-1:0] cnt;
  logic [WIDTH_W-1:0] eff;

  assign eff = (width == '0) ? WIDTH_W'(1) : width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!clr_lvl) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (fire) begin
      q   <= 1'b1;
      cnt <= eff - WIDTH_W'(1);
    end else if (q) begin
      if (cnt == '0) begin
        q <= 1'b0;
      end else begin
        cnt <= cnt - WIDTH_W'(1);
      end
    end
  end

endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot
  import retrig_oneshot_pkg::*;
#(
  parameter int WIDTH_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYC    = 1,
  parameter int REC_CYC     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall_trig_i,
  input  logic               rise_trig_i,
  input  logic               clr_n_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               qn_o
);

  // idle levels used as synchroniser reset values, and edge kinds per pin
  localparam logic [NUM_PINS-1:0] IDLE_LVL  = 3'b101;
  localparam logic [NUM_PINS-1:0] RISE_KIND = 3'b110;

  logic [NUM_PINS-1:0] raw;
  logic [NUM_PINS-1:0] lvl;
  logic [NUM_PINS-1:0] evt;
  logic                fire;
  logic                lock_busy;
  logic                rec_busy;
  logic                clr_lvl;
  logic                q_int;

  assign raw[PIN_FALL] = fall_trig_i;
  assign raw[PIN_RISE] = rise_trig_i;
  assign raw[PIN_CLR]  = clr_n_i;

  generate
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      ros_edge_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LVL[gi]),
        .KIND    (RISE_KIND[gi] ? EDGE_RISE : EDGE_FALL)
      ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw[gi]),
        .lvl   (lvl[gi]),
        .evt   (evt[gi])
      );
    end
  endgenerate

  assign clr_lvl = lvl[PIN_CLR];

  ros_trig_gate #(
    .LOCK_CYC (LOCK_CYC),
    .REC_CYC  (REC_CYC)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_lvl     (lvl[PIN_FALL]),
    .a_evt     (evt[PIN_FALL]),
    .b_lvl     (lvl[PIN_RISE]),
    .b_evt     (evt[PIN_RISE]),
    .c_lvl     (clr_lvl),
    .c_evt     (evt[PIN_CLR]),
    .q_act     (q_int),
    .fire      (fire),
    .lock_busy (lock_busy),
    .rec_busy  (rec_busy)
  );

  ros_pulse_timer #(
    .WIDTH_W (WIDTH_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .clr_lvl (clr_lvl),
    .width   (width_i),
    .q       (q_int)
  );

  assign q_o  = q_int;
  assign qn_o = ~q_int;

endmodule

// File: rtl/retrig_oneshot_chk.sv
`timescale 1ns/1ps
module retrig_oneshot_chk #(
  parameter int REC_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic q,
  input logic fire,
  input logic clr_lvl,
  input logic rec_busy
);

  // R7: an accepted trigger raises the output on the next edge
  p_fire_sets_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> q);

  // R6: the output only rises as the result of an accepted trigger
  p_rise_from_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(fire));

  // R5: a low clear level drives the output low on the next edge
  p_clear_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_lvl |=> !q);

  // R8: two accepted triggers never fall on consecutive edges
  p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R9: a clear during a running pulse arms the recovery interval
  p_recovery_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((REC_CYC > 0) && !clr_lvl && q) |=> rec_busy);

endmodule

bind retrig_oneshot retrig_oneshot_chk #(
  .REC_CYC (REC_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .q        (q_o),
  .fire     (fire),
  .clr_lvl  (clr_lvl),
  .rec_busy (rec_busy)
);

// File: tb/retrig_oneshot_tb_top.sv
`timescale 1ns/1ps
module retrig_oneshot_tb_top;

  localparam int WW = 8;
  localparam int LK = 3;
  localparam int RC = 2;

  typedef struct packed {
    logic [2:0] pre;   // {fall, rise, clr}
    logic [2:0] post;
    logic [7:0] w;
    logic [7:0] exp_hi;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'b111, 3'b011, 8'd5, 8'd5, 8'd2},  // R2 valid falling trigger
    '{3'b101, 3'b001, 8'd5, 8'd0, 8'd2},  // R2 rise pin low blocks
    '{3'b110, 3'b010, 8'd5, 8'd0, 8'd5},  // R5 clear low blocks
    '{3'b001, 3'b011, 8'd7, 8'd7, 8'd3},  // R3 valid rising trigger
    '{3'b101, 3'b111, 8'd7, 8'd0, 8'd3},  // R3 fall pin high blocks
    '{3'b010, 3'b011, 8'd4, 8'd4, 8'd4},  // R4 clear release triggers
    '{3'b000, 3'b001, 8'd4, 8'd0, 8'd4},  // R4 rise pin low blocks
    '{3'b111, 3'b011, 8'd0, 8'd1, 8'd10}, // R10 width zero
    '{3'b001, 3'b011, 8'd1, 8'd1, 8'd10}, // R10 width one
    '{3'b011, 3'b111, 8'd5, 8'd0, 8'd11}, // R11 wrong edge on fall pin
    '{3'b011, 3'b001, 8'd5, 8'd0, 8'd11}, // R11 wrong edge on rise pin
    '{3'b110, 3'b111, 8'd3, 8'd0, 8'd4}   // R4 fall pin high blocks
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fa = 1'b1;
  logic          rb = 1'b1;
  logic          cn = 1'b1;
  logic [WW-1:0] wd = 8'd5;
  logic          q;
  logic          qn;

  int n_run = 0;
  int n_fail = 0;
  int hc = 0;
  bit comp_bad = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  retrig_oneshot #(
    .WIDTH_W     (WW),
    .SYNC_STAGES (2),
    .LOCK_CYC    (LK),
    .REC_CYC     (RC)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_trig_i (fa),
    .rise_trig_i (rb),
    .clr_n_i     (cn),
    .width_i     (wd),
    .q_o         (q),
    .qn_o        (qn)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic count_high(input int n);
    hc = 0;
    repeat (n) begin
      @(negedge clk);
      if (q) hc++;
      if (qn !== ~q) comp_bad = 1'b1;
    end
  endtask

  task automatic set_in(input logic [2:0] v);
    fa = v[2];
    rb = v[1];
    cn = v[0];
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int first;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 q in reset", int'(q), 0);
    check("R1 qn in reset", int'(qn), 1);
    @(posedge clk); #2;
    rst_n = 1'b1;
    count_high(10);
    check("R1 idle after reset", hc, 0);

    // table-driven gating cases
    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i].pre);
      wd = VEC[i].w;
      tick(30);
      set_in(VEC[i].post);
      count_high(25);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), hc, int'(VEC[i].exp_hi));
    end

    // R7: fixed latency for short and long widths
    for (int k = 0; k < 2; k++) begin
      set_in(3'b111);
      wd = (k == 0) ? 8'd1 : 8'd40;
      tick(30);
      set_in(3'b011);
      first = -1;
      for (int n = 0; n < 6; n++) begin
        @(negedge clk);
        if (q && first < 0) first = n;
      end
      check($sformatf("R7 latency width %0d", wd), first, 3);
      tick(60);
    end

    // R6: retrigger four edges after the first trigger
    set_in(3'b111); wd = 8'd6; tick(30);
    fork
      count_high(40);
      begin
        set_in(3'b011); tick(2); fa = 1'b1; tick(2); fa = 1'b0;
      end
    join
    check("R6 retrigger extends", hc, 10);

    // R8: retrigger two and three edges after (blocked), four after (taken)
    for (int d = 2; d <= 4; d++) begin
      set_in(3'b111); wd = 8'd4; tick(30);
      fork
        count_high(30);
        begin
          fa = 1'b0; tick(1); rb = 1'b0; tick(d - 1); rb = 1'b1;
        end
      join
      check($sformatf("R8 lockout offset %0d", d), hc, (d == 4) ? 8 : 4);
    end

    // R5 and R9: abort, ignored triggers, swallowed clear release, recovery
    set_in(3'b111); wd = 8'd20; tick(30);
    fork
      count_high(8);
      begin
        fa = 1'b0; tick(5); cn = 1'b0;
      end
    join
    check("R5 abort shortens pulse", hc, 5);
    fork
      count_high(20);
      begin
        rb = 1'b0; tick(3); rb = 1'b1; tick(3); fa = 1'b1; tick(3); fa = 1'b0;
      end
    join
    check("R5 triggers ignored while clear low", hc, 0);
    fork
      count_high(20);
      cn = 1'b1;
    join
    check("R9 clear release swallowed", hc, 0);
    set_in(3'b111); tick(5);
    fa = 1'b0;
    count_high(30);
    check("R9 trigger after recovery", hc, 20);

    // R10: width change during a pulse has no effect
    set_in(3'b111); wd = 8'd5; tick(30);
    fork
      count_high(30);
      begin
        fa = 1'b0; tick(4); wd = 8'd25;
      end
    join
    check("R10 width sampled at trigger", hc, 5);

    check("R1 qn complement throughout", int'(comp_bad), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule